// File: doc/BRIEF.md
# Bidirectional Gate Scan Shift Register

This block is the logic core of a row-scan driver for an active-matrix display panel. A single start pulse enters a chain of 240 flip-flop stages and advances one stage on each rising edge of the scan clock. Each stage drives one gate-enable output, so a single pulse walks across the panel rows one after another. A direction select picks whether the walk runs from the lowest output upward or from the highest active output downward. A length select shortens the chain to 220 active stages. When it is set, the upper twenty outputs stay inactive.

Two active-low blanking inputs force every gate output inactive without disturbing the pulse position held in the chain. The combinational blank acts at once, with no clock. The clocked blank is sampled on each scan edge and holds the outputs off from that edge onward. A cascade output is high while the final stage of the current direction holds the pulse, so a second driver can carry on the scan.

Top module: `gate_scan_sr`

## Requirements
- R1: While `rst` is high on a rising clock edge, every stage clears. After that edge `gate_en` is all zero and `cascade_out` is 0.
- R2: With `dir_up`=1, the value of `start_in` is loaded into bit 0 (G1) on a rising edge and is visible on `gate_en` right after that edge. On each later edge it moves to the next higher bit.
- R3: With `dir_up`=0 and `short_len`=0, `start_in` is loaded into bit 239 (G240) on a rising edge. On each later edge it moves to the next lower bit, down to bit 0.
- R4: With `dir_up`=0 and `short_len`=1, `start_in` is loaded into bit 219 (G220). It then moves down to bit 0.
- R5: With `short_len`=1, bits 220 to 239 of `gate_en` are always 0. In the upward direction, a pulse that leaves bit 219 disappears.
- R6: `cascade_out` is 1 exactly while the last stage of the current scan holds the pulse. Upward, that stage is bit 239, or bit 219 when `short_len`=1. Downward, it is bit 0. The blanking inputs do not affect `cascade_out`.
- R7: While `blank_now_n` is 0, `gate_en` is all zero at once, with no clock edge. The pulse keeps shifting, and when `blank_now_n` returns to 1 the output shows the pulse at its current position.
- R8: `blank_sync_n` is sampled on each rising edge. A 0 that is sampled forces `gate_en` to all zero from that edge until an edge samples 1. A change between edges has no effect until the next edge.
- R9: While a sampled `blank_sync_n` of 0 is in force, `gate_en` stays all zero even when `blank_now_n` is 1.
- R10: For a single start pulse and no blanking, exactly one `gate_en` bit is 1 on each of the active-length edges after capture, in all four combinations of direction and length. After those edges, no bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; shifting on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Start-pulse data captured into the first stage of the scan |
| dir_up | input | 1 | 1: scan upward from G1; 0: scan downward to G1 |
| short_len | input | 1 | 1: 220 active stages; 0: 240 active stages |
| blank_now_n | input | 1 | Active-low immediate blank of all gate outputs |
| blank_sync_n | input | 1 | Active-low blank, sampled on the scan clock, dominant |
| gate_en | output | 240 | One gate enable per row, bit 0 is G1 |
| cascade_out | output | 1 | High while the final stage of the scan holds the pulse |

## Verification
The hardest condition to reach is the pulse sitting in the final stage while the clocked blank is in force. Only there does the cascade output have to stay high while every gate output is forced low. The stimulus launches one upward pulse and asserts the clocked blank partway along the chain. It then holds that blank through more than two hundred edges, until the pulse reaches bit 239, and checks both outputs there. Immediate blanking is toggled between edges while the pulse is in flight, which shows that the position keeps advancing while hidden.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  // Index of the final stage reached by an upward scan.
  function automatic int unsigned top_stage(input logic short_len,
                                            input int unsigned full_n,
                                            input int unsigned short_n);
    return short_len ? short_n - 1 : full_n - 1;
  endfunction

endpackage

// File: rtl/gsr_shift_chain.sv
module gsr_shift_chain #(
  parameter int unsigned N_STAGES = 240,
  parameter int unsigned N_SHORT  = 220
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_in,
  input  logic                dir_up,
  input  logic                short_len,
  output logic [N_STAGES-1:0] chain_q,
  output logic                cascade_out
);
  import gsr_pkg::*;

  localparam int unsigned TOP_FULL  = N_STAGES - 1;
  localparam int unsigned TOP_SHORT = N_SHORT - 1;

  logic [N_STAGES-1:0] nxt;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic up_src, dn_src, live;
    if (i == 0) begin : g_up_head
      assign up_src = start_in;
    end else begin : g_up_body
      assign up_src = chain_q[i-1];
    end
    if (i == TOP_FULL) begin : g_dn_head
      assign dn_src = start_in;
    end else if (i == TOP_SHORT) begin : g_dn_short_head
      assign dn_src = short_len ? start_in : chain_q[i+1];
    end else begin : g_dn_body
      assign dn_src = chain_q[i+1];
    end
    if (i < N_SHORT) begin : g_always_live
      assign live = 1'b1;
    end else begin : g_tail_live
      assign live = ~short_len;
    end
    assign nxt[i] = live & (dir_up ? up_src : dn_src);
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= nxt;
  end

  assign cascade_out = dir_up ? chain_q[top_stage(short_len, N_STAGES, N_SHORT)]
                              : chain_q[0];

  // R2: upward capture into the first stage
  p_up_capture_r2: assert property (@(posedge clk) disable iff (rst)
    dir_up |=> chain_q[0] == $past(start_in));
  // R2: upward shift by one stage
  p_up_shift_r2: assert property (@(posedge clk) disable iff (rst)
    dir_up |=> chain_q[1] == $past(chain_q[0]));
  // R3: downward shift over the full chain
  p_dn_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && !short_len) |=> chain_q[TOP_FULL-1] == $past(chain_q[TOP_FULL]));
  // R4: downward capture at the short head
  p_dn_short_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && short_len) |=> chain_q[TOP_SHORT] == $past(start_in));
  // R5: tail stays clear in short mode
  p_tail_clear_r5: assert property (@(posedge clk) disable iff (rst)
    short_len |=> chain_q[TOP_FULL:N_SHORT] == '0);

endmodule

// File: rtl/gsr_blank_ctrl.sv
module gsr_blank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic blank_now_n,
  input  logic blank_sync_n,
  output logic blank
);
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= ~blank_sync_n;
  end

  assign blank = sync_q | ~blank_now_n;

  // R8: sampled blank is held for one full cycle
  p_sync_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !blank_sync_n |=> blank);

endmodule

// File: rtl/gsr_gate_out.sv
module gsr_gate_out #(
  parameter int unsigned N_STAGES = 240,
  parameter int unsigned N_SHORT  = 220
) (
  input  logic [N_STAGES-1:0] chain_q,
  input  logic                blank,
  input  logic                short_len,
  output logic [N_STAGES-1:0] gate_en
);
  for (genvar i = 0; i < N_STAGES; i++) begin : g_out
    if (i < N_SHORT) begin : g_low
      assign gate_en[i] = chain_q[i] & ~blank;
    end else begin : g_high
      assign gate_en[i] = chain_q[i] & ~blank & ~short_len;
    end
  end
endmodule

// File: rtl/gate_scan_sr.sv
module gate_scan_sr #(
  parameter int unsigned N_STAGES = 240,
  parameter int unsigned N_SHORT  = 220
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_in,
  input  logic                dir_up,
  input  logic                short_len,
  input  logic                blank_now_n,
  input  logic                blank_sync_n,
  output logic [N_STAGES-1:0] gate_en,
  output logic                cascade_out
);
  logic [N_STAGES-1:0] chain_q;
  logic                blank;

  gsr_shift_chain #(.N_STAGES(N_STAGES), .N_SHORT(N_SHORT)) u_chain (
    .clk(clk), .rst(rst), .start_in(start_in), .dir_up(dir_up),
    .short_len(short_len), .chain_q(chain_q), .cascade_out(cascade_out));

  gsr_blank_ctrl u_blank (
    .clk(clk), .rst(rst), .blank_now_n(blank_now_n),
    .blank_sync_n(blank_sync_n), .blank(blank));

  gsr_gate_out #(.N_STAGES(N_STAGES), .N_SHORT(N_SHORT)) u_out (
    .chain_q(chain_q), .blank(blank), .short_len(short_len), .gate_en(gate_en));

  // R1: reset clears outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (gate_en == '0 && !cascade_out));
  // R7: immediate blank
  p_now_blank_r7: assert property (@(posedge clk) disable iff (rst)
    !blank_now_n |-> gate_en == '0);
  // R8 and R9: sampled blank dominates
  p_sync_blank_r9: assert property (@(posedge clk) disable iff (rst)
    (!blank_sync_n && blank_now_n) |=> gate_en == '0);

endmodule

// File: tb/gate_scan_sr_tb.sv
module gate_scan_sr_tb;
  localparam int N = 240;
  localparam int S = 220;
  localparam time CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_in = 1'b0;
  logic dir_up = 1'b1;
  logic short_len = 1'b0;
  logic blank_now_n = 1'b1;
  logic blank_sync_n = 1'b1;
  logic [N-1:0] gate_en;
  logic cascade_out;

  int n_checks = 0;
  int n_fail = 0;

  gate_scan_sr #(.N_STAGES(N), .N_SHORT(S)) u_dut (
    .clk(clk), .rst(rst), .start_in(start_in), .dir_up(dir_up),
    .short_len(short_len), .blank_now_n(blank_now_n),
    .blank_sync_n(blank_sync_n), .gate_en(gate_en), .cascade_out(cascade_out));

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  function automatic logic [N-1:0] one_at(input int p);
    logic [N-1:0] v = '0;
    if (p >= 0 && p < N) v[p] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s gate_en actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cascade_out actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start_in = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  // One pulse through one configuration of direction and length
  task automatic sweep(input logic up, input logic shrt, input string req);
    int len;
    len = shrt ? S : N;
    dir_up = up; short_len = shrt;
    do_reset();
    chk_vec("R1", gate_en, '0);
    chk_bit("R1", cascade_out, 1'b0);
    start_in = 1'b1;
    tick();
    start_in = 1'b0;
    for (int k = 0; k < len; k++) begin
      int p;
      p = up ? k : len - 1 - k;
      chk_vec(req, gate_en, one_at(p));
      chk_bit("R6", cascade_out, k == len - 1);
      if (shrt) chk_vec("R5", gate_en & ~one_at(-1) & {{(N-S){1'b1}}, {S{1'b0}}}, '0);
      tick();
    end
    chk_vec("R10", gate_en, '0);
    chk_bit("R10", cascade_out, 1'b0);
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    sweep(1'b1, 1'b0, "R2");
    sweep(1'b0, 1'b0, "R3");
    sweep(1'b0, 1'b1, "R4");
    sweep(1'b1, 1'b1, "R5");

    // Blanking behaviour, upward full chain
    dir_up = 1'b1; short_len = 1'b0;
    do_reset();
    start_in = 1'b1; tick(); start_in = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk_vec("R2", gate_en, one_at(5));
    blank_now_n = 1'b0; #1;
    chk_vec("R7", gate_en, '0);
    for (int k = 0; k < 3; k++) tick();
    chk_vec("R7", gate_en, '0);
    blank_now_n = 1'b1; #1;
    chk_vec("R7", gate_en, one_at(8));
    blank_sync_n = 1'b0; #1;
    chk_vec("R8", gate_en, one_at(8));
    tick();
    chk_vec("R8", gate_en, '0);
    chk_vec("R9", gate_en, '0);
    for (int k = 9; k < 20; k++) tick();
    blank_sync_n = 1'b1; #1;
    chk_vec("R8", gate_en, '0);
    tick();
    chk_vec("R8", gate_en, one_at(21));
    blank_sync_n = 1'b0;
    for (int k = 21; k < N - 1; k++) tick();
    chk_vec("R9", gate_en, '0);
    chk_bit("R6", cascade_out, 1'b1);
    blank_sync_n = 1'b1;
    tick();
    chk_vec("R10", gate_en, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule